// File: doc/BRIEF.md
# Frame Sync Offset Evaluator

This block measures how far a chosen frame-sync input lags the master sync pulse, in device clock periods. Once the result is known, the input alignment of the switch can be programmed. A command names one of eight frame-sync lines and arms a measurement. The evaluator does not measure until the synchronized-state flag is high.

An armed measurement waits for a rising edge of the master sync pulse. It then counts clock periods until the selected frame-sync line rises, and the count wraps at the frame length. When that edge arrives, the count is stored in a result register and a completion flag is raised. A read strobe on the interrupt status clears the flag. The result register has no reset value and is only meaningful after the first completion.

Top module: `fs_offset_eval`

## Requirements
- R1: After reset, `busy` and `fec_flag` are low.
- R2: `cmd_addr` (binary index 0..NUM_FS-1) is captured with `cmd_valid` and picks the one frame-sync line that ends the measurement; rising edges on all other lines are ignored.
- R3: The result is the number of clock periods from the cycle in which a rising edge of `sp` is seen to the cycle in which a rising edge of the selected line is seen, modulo FRAME_LEN; both edges in the same cycle give 0.
- R4: While `synced` is low, no measurement completes; an armed evaluation waits, with `busy` high, until `synced` is high and a new `sp` rising edge arrives.
- R5: If `synced` drops during a measurement, the partial count is discarded and the evaluation re-arms, waiting for sync and a fresh `sp` edge.
- R6: On completion, `result` is loaded, `fec_flag` rises and `busy` falls, all visible in the cycle after the selected edge is sampled.
- R7: A high `ista_rd` clears `fec_flag`; when a completion happens in the same cycle, the flag stays set.
- R8: A `cmd_valid` during a running evaluation restarts it with the new address, and the old line no longer ends it.
- R9: `result` keeps its value while no evaluation completes, including across sync and frame-sync activity while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | device clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sp | input | 1 | master sync pulse |
| fs_in | input | NUM_FS | frame-sync inputs |
| synced | input | 1 | synchronized-state flag |
| cmd_valid | input | 1 | start-evaluation command strobe |
| cmd_addr | input | SELW | index of the frame-sync line to evaluate |
| ista_rd | input | 1 | interrupt status read strobe, clears the flag |
| busy | output | 1 | evaluation armed or counting |
| fec_flag | output | 1 | evaluation-completed flag |
| result | output | CW | measured offset in clock periods |

## Verification
The bench sweeps every address against every offset from 0 to FRAME_LEN-1 on a 16-cycle frame. In each run, the lines that are not selected pulse together with the sync pulse, which separates correct line selection from any-edge triggering. One offset beyond the frame length checks the wrap. Further directed runs cover holding while unsynchronized, sync loss partway through a count, a restart by a second command followed by an edge on the abandoned line, a read strobe coinciding with completion, and sync activity after completion to confirm that the result is held.

// File: rtl/fs_offset_eval.sv
module fs_offset_eval #(
  parameter int NUM_FS    = 8,
  parameter int FRAME_LEN = 1024,
  parameter int SELW      = $clog2(NUM_FS),
  parameter int CW        = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp,
  input  logic [NUM_FS-1:0] fs_in,
  input  logic              synced,
  input  logic              cmd_valid,
  input  logic [SELW-1:0]   cmd_addr,
  input  logic              ista_rd,
  output logic              busy,
  output logic              fec_flag,
  output logic [CW-1:0]     result
);

  typedef enum logic [1:0] {IDLE, ARM, HUNT, COUNT} st_t;

  localparam logic [CW-1:0] CNT_LAST = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  st_t              st;
  logic [SELW-1:0]  sel;
  logic             sp_q;
  logic [NUM_FS-1:0] fs_q;
  logic [CW-1:0]    cnt;

  wire sp_rise = sp & ~sp_q;
  wire fs_rise = fs_in[sel] & ~fs_q[sel];
  wire hit_now = (st == HUNT) && sp_rise && fs_rise;
  wire hit_cnt = (st == COUNT) && fs_rise;
  wire done    = !cmd_valid && synced && (hit_now || hit_cnt);

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      sel  <= '0;
      sp_q <= 1'b0;
      fs_q <= '0;
      cnt  <= '0;
    end else begin
      sp_q <= sp;
      fs_q <= fs_in;
      if (cmd_valid) begin
        st  <= ARM;
        sel <= cmd_addr;
      end else begin
        case (st)
          ARM:  if (synced) st <= HUNT;
          HUNT: begin
            if (!synced) st <= ARM;
            else if (sp_rise) begin
              if (fs_rise) st <= IDLE;
              else begin
                st  <= COUNT;
                cnt <= CNT_ONE;
              end
            end
          end
          COUNT: begin
            if (!synced) st <= ARM;
            else if (fs_rise) st <= IDLE;
            else cnt <= (cnt == CNT_LAST) ? '0 : cnt + CNT_ONE;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fec_flag <= 1'b0;
    else if (done)     fec_flag <= 1'b1;
    else if (ista_rd)  fec_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (done) result <= hit_now ? '0 : cnt;
  end

endmodule

// File: rtl/fs_offset_eval_chk.sv
module fs_offset_eval_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          synced,
  input logic          ista_rd,
  input logic          busy,
  input logic          fec_flag,
  input logic [CW-1:0] result
);

  a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !fec_flag);

  a_r8_cmd_arms: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> busy);

  a_r4_no_done_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> !$rose(fec_flag));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fec_flag) |-> !busy);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ista_rd && !busy |=> !fec_flag);

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

endmodule

bind fs_offset_eval fs_offset_eval_chk #(.CW(CW)) u_chk (.*);

// File: tb/fs_offset_eval_tb.sv
module fs_offset_eval_tb;
  localparam int NFS = 8;
  localparam int FL  = 16;
  localparam int SW  = 3;
  localparam int CWB = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sp = 1'b0;
  logic [NFS-1:0] fs_in = '0;
  logic           synced = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [SW-1:0]  cmd_addr = '0;
  logic           ista_rd = 1'b0;
  logic           busy, fec_flag;
  logic [CWB-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  fs_offset_eval #(.NUM_FS(NFS), .FRAME_LEN(FL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sp(sp), .fs_in(fs_in), .synced(synced),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .ista_rd(ista_rd),
    .busy(busy), .fec_flag(fec_flag), .result(result)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_flag();
    ista_rd = 1'b1; tick(); ista_rd = 1'b0;
    chk(fec_flag == 1'b0, "R7 read clears flag", fec_flag, 0);
  endtask

  task automatic issue(int a);
    cmd_valid = 1'b1; cmd_addr = SW'(a); tick();
    cmd_valid = 1'b0; tick();
  endtask

  task automatic run(int a, int d);
    sp = 1'b1;
    if (d == 0) fs_in[a] = 1'b1;
    else fs_in = ~(NFS'(1) << a);
    tick();
    sp = 1'b0; fs_in = '0;
    for (int k = 1; k <= d; k++) begin
      if (k == d) fs_in[a] = 1'b1;
      tick();
      fs_in = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(fec_flag == 1'b0, "R1 flag after reset", fec_flag, 0);
    synced = 1'b1;

    // R2 R3 R6: full sweep with distractor edges on other lines
    for (int a = 0; a < NFS; a++) begin
      for (int d = 0; d < FL; d++) begin
        issue(a);
        chk(busy == 1'b1, "R6 busy while armed", busy, 1);
        run(a, d);
        chk(result == CWB'(d), "R3 R2 offset", result, d);
        chk(fec_flag == 1'b1, "R6 flag set", fec_flag, 1);
        chk(busy == 1'b0, "R6 busy cleared", busy, 0);
        clear_flag();
      end
    end

    // R3 wrap beyond frame length
    issue(3); run(3, FL + 3);
    chk(result == CWB'(3), "R3 wrap", result, 3);
    clear_flag();

    // R4 hold while unsynchronized
    synced = 1'b0;
    issue(2); run(2, 3);
    chk(fec_flag == 1'b0, "R4 no completion unsynced", fec_flag, 0);
    chk(busy == 1'b1, "R4 still waiting", busy, 1);
    synced = 1'b1; tick();
    run(2, 5);
    chk(result == CWB'(5), "R4 result after sync", result, 5);
    chk(fec_flag == 1'b1, "R4 flag after sync", fec_flag, 1);
    clear_flag();

    // R5 sync loss mid count
    issue(4);
    sp = 1'b1; tick(); sp = 1'b0;
    synced = 1'b0; tick();
    synced = 1'b1; fs_in[4] = 1'b1; tick(); fs_in = '0;
    chk(fec_flag == 1'b0, "R5 partial discarded", fec_flag, 0);
    chk(busy == 1'b1, "R5 re-armed", busy, 1);
    run(4, 7);
    chk(result == CWB'(7), "R5 result after re-arm", result, 7);
    clear_flag();

    // R8 restart with new address
    issue(1);
    sp = 1'b1; tick(); sp = 1'b0; tick();
    issue(6);
    fs_in[1] = 1'b1; tick(); fs_in = '0;
    chk(fec_flag == 1'b0, "R8 old line ignored", fec_flag, 0);
    run(6, 9);
    chk(result == CWB'(9), "R8 new address result", result, 9);
    clear_flag();

    // R7 read coincident with completion
    issue(0);
    sp = 1'b1; tick(); sp = 1'b0;
    fs_in[0] = 1'b1; ista_rd = 1'b1; tick(); fs_in = '0; ista_rd = 1'b0;
    chk(fec_flag == 1'b1, "R7 set wins over read", fec_flag, 1);
    chk(result == CWB'(1), "R7 result", result, 1);
    clear_flag();

    // R9 idle activity leaves result
    run(0, 4);
    run(5, 2);
    chk(result == CWB'(1), "R9 result held", result, 1);
    chk(fec_flag == 1'b0, "R9 no flag while idle", fec_flag, 0);
    chk(busy == 1'b0, "R9 stays idle", busy, 0);

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule